// File: doc/BRIEF.md
# Glitch-free gated clock fanout

This block distributes one clock to six loads. A select line picks either a fast system clock or a slower scan/test clock. Six gated copies of the picked clock leave the block. A common enable applies to all copies, and a per-copy enable applies to each one. The enables are not applied combinationally. A bank of flip-flops clocked on the falling edge of the picked clock samples them. A copy can therefore change state only while the clock is low, so turning a copy on or off never shortens a high phase.

The block is meant as the first level of a clock tree, where single loads can be parked without disturbing the others. The enable inputs are active high. At integration they should be tied or pulled to the enabled level, so that a load left unconnected keeps its clock. The select line may only be changed while every copy is disabled. A synchronous active-high reset, sampled on the falling edge of the picked clock, parks every copy low.

Top module: `gated_clk_fanout`

## Requirements
- R1: With `sel_scan` = 0 the outputs follow `clk_sys`. With `sel_scan` = 1 they follow `clk_scan`. An enabled output's high pulse lasts one high phase of the selected clock: 10 ns for the 50 MHz system clock and 30 ns for the scan clock in the bench.
- R2: No output is ever high while the selected clock is low.
- R3: The enables are sampled only on a falling edge of the selected clock. A change made during a high phase has no effect on that phase.
- R4: During a high phase, output i is high exactly when `en_all` and `en_out[i]` were both 1 at the preceding falling edge. Otherwise it is low.
- R5: Once an output is disabled at a falling edge, it stays low for every following high phase until it is enabled again.
- R6: After being enabled at a falling edge, an output's first pulse starts at the next rising edge and lasts a full high phase.
- R7: While `rst` = 1 at a falling edge of the selected clock, every output is held low from that edge on.
- R8: Under any timing of enable changes, every high pulse on every output lasts exactly one high phase of the selected clock. No runt pulses occur.
- R9: Disabling one output through its own enable does not affect the other outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Fast system clock |
| clk_scan | input | 1 | Slow scan/test clock |
| sel_scan | input | 1 | Source select: 0 = system clock, 1 = scan clock |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge of the selected clock |
| en_all | input | 1 | Common enable for all outputs, active high |
| en_out | input | 6 | Per-output enables, active high, bit i for output i |
| clk_out | output | 6 | Gated clock copies |

## Verification
The hardest case to reach is an enable that changes in the middle of a high phase. A combinational gate would chop that phase into a runt, but the block must hold it until the next falling edge. The stimulus moves the enables at random offsets inside both phases of both clocks. A pulse-width monitor on every output measures each high pulse against the selected clock's half period. Source switches are exercised the only legal way: the bench parks all outputs, flips the select line, waits, and re-enables them.

// File: rtl/gated_clk_fanout_pkg.sv
package gated_clk_fanout_pkg;

    localparam int unsigned FANOUT_DEFAULT = 6;

    typedef enum logic {
        SRC_SYS  = 1'b0,
        SRC_SCAN = 1'b1
    } clk_src_e;

    function automatic clk_src_e decode_src(input logic sel);
        return sel ? SRC_SCAN : SRC_SYS;
    endfunction

endpackage

// File: rtl/fanout_src_mux.sv
module fanout_src_mux
    import gated_clk_fanout_pkg::*;
(
    input  logic clk_sys,
    input  logic clk_scan,
    input  logic sel_scan,
    output logic clk_pick
);
    clk_src_e src;

    always_comb begin
        src = decode_src(sel_scan);
        unique case (src)
            SRC_SCAN: clk_pick = clk_scan;
            default:  clk_pick = clk_sys;
        endcase
    end
endmodule

// File: rtl/fanout_en_capture.sv
module fanout_en_capture #(
    parameter int unsigned N = 6
) (
    input  logic         clk_pick,
    input  logic         rst,
    input  logic         en_all,
    input  logic [N-1:0] en_out,
    output logic [N-1:0] en_q
);
    logic [N-1:0] en_next;

    always_comb begin
        en_next = en_out & {N{en_all}};
    end

    // Enables are captured on the falling edge, so they only change while the clock is low.
    always_ff @(negedge clk_pick) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_next;
        end
    end
endmodule

// File: rtl/fanout_gate.sv
module fanout_gate #(
    parameter int unsigned N = 6
) (
    input  logic         clk_pick,
    input  logic [N-1:0] en_q,
    output logic [N-1:0] clk_out
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        assign clk_out[i] = clk_pick & en_q[i];
    end
endmodule

// File: rtl/gated_clk_fanout.sv
module gated_clk_fanout
    import gated_clk_fanout_pkg::*;
#(
    parameter int unsigned N = FANOUT_DEFAULT
) (
    input  logic         clk_sys,
    input  logic         clk_scan,
    input  logic         sel_scan,
    input  logic         rst,
    input  logic         en_all,
    input  logic [N-1:0] en_out,
    output logic [N-1:0] clk_out
);
    logic         clk_pick;
    logic [N-1:0] en_q;

    fanout_src_mux u_mux (
        .clk_sys  (clk_sys),
        .clk_scan (clk_scan),
        .sel_scan (sel_scan),
        .clk_pick (clk_pick)
    );

    fanout_en_capture #(.N(N)) u_cap (
        .clk_pick (clk_pick),
        .rst      (rst),
        .en_all   (en_all),
        .en_out   (en_out),
        .en_q     (en_q)
    );

    fanout_gate #(.N(N)) u_gate (
        .clk_pick (clk_pick),
        .en_q     (en_q),
        .clk_out  (clk_out)
    );
endmodule

// File: rtl/gated_clk_fanout_chk.sv
module gated_clk_fanout_chk #(
    parameter int unsigned N = 6
) (
    input logic         clk_pick,
    input logic         rst,
    input logic         en_all,
    input logic [N-1:0] en_out,
    input logic [N-1:0] clk_out
);
    // Sampled just before a falling edge the clock is high, so outputs show the enables captured one edge earlier.
    assert_enabled_follow_R4: assert property (@(negedge clk_pick) disable iff (rst)
        en_all |=> clk_out == $past(en_out))
        else $error("assert_enabled_follow_R4");

    assert_common_off_R5: assert property (@(negedge clk_pick) disable iff (rst)
        !en_all |=> clk_out == '0)
        else $error("assert_common_off_R5");

    // Just before a rising edge the clock has been low: outputs must be low.
    assert_low_phase_R2: assert property (@(posedge clk_pick) disable iff (rst)
        clk_out == '0)
        else $error("assert_low_phase_R2");

    assert_hold_high_R3: assert property (@(posedge clk_pick) disable iff (rst)
        $stable(clk_out) |-> clk_out == '0)
        else $error("assert_hold_high_R3");
endmodule

bind gated_clk_fanout gated_clk_fanout_chk #(.N(N)) u_chk (
    .clk_pick (clk_pick),
    .rst      (rst),
    .en_all   (en_all),
    .en_out   (en_out),
    .clk_out  (clk_out)
);

// File: tb/tb_gated_clk_fanout.sv
`timescale 1ns/1ps
module tb_gated_clk_fanout;
    localparam int N = 6;

    logic         clk_sys = 1'b0;
    logic         clk_scan = 1'b0;
    logic         sel_scan = 1'b0;
    logic         rst = 1'b1;
    logic         en_all = 1'b1;
    logic [N-1:0] en_out = '1;
    logic [N-1:0] clk_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    gated_clk_fanout #(.N(N)) dut (
        .clk_sys  (clk_sys),
        .clk_scan (clk_scan),
        .sel_scan (sel_scan),
        .rst      (rst),
        .en_all   (en_all),
        .en_out   (en_out),
        .clk_out  (clk_out)
    );

    always #10 clk_sys = ~clk_sys;
    always #30 clk_scan = ~clk_scan;

    // Selected clock and captured enables as the requirements define them.
    logic         bpick;
    logic [N-1:0] mq;
    assign bpick = sel_scan ? clk_scan : clk_sys;

    always @(negedge bpick) begin
        mq <= rst ? '0 : (en_out & {N{en_all}});
    end

    function automatic int half_period(input logic sel);
        return sel ? 30 : 10;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison in the middle of every 10 ns slot.
    initial begin
        logic [N-1:0] exp;
        #45;
        forever begin
            exp = (bpick === 1'b1) ? mq : '0;
            chk(clk_out === exp, (bpick === 1'b1) ? "R4" : "R2", clk_out, exp);
            #10;
        end
    end

    // Pulse width monitor on every output.
    time          rise_t [N];
    logic [N-1:0] prev_out = '0;
    always @(clk_out) begin
        for (int i = 0; i < N; i++) begin
            if (clk_out[i] === 1'b1 && prev_out[i] !== 1'b1) begin
                rise_t[i] = $time;
            end else if (clk_out[i] !== 1'b1 && prev_out[i] === 1'b1) begin
                chk_int(($time - rise_t[i]) == half_period(sel_scan),
                        sel_scan ? "R8 R1 scan width" : "R8 width",
                        int'($time - rise_t[i]), half_period(sel_scan));
            end
        end
        prev_out = clk_out;
    end

    // Wait until a rising edge of the selected clock, plus 2 ns.
    task automatic to_high_plus2();
        @(posedge bpick);
        #2;
    endtask

    task automatic to_mid_high();
        #(half_period(sel_scan) / 2 - 2);
    endtask

    task automatic switch_source(input logic new_sel);
        en_all = 1'b0;
        #200;
        sel_scan = new_sel;
        #200;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #5ms;
        failures++;
        $display("FAIL watchdog expired t=%0t", $time);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));

        // R7: reset with all enables asserted keeps outputs low.
        to_high_plus2();
        to_mid_high();
        chk(clk_out === '0, "R7 reset", clk_out, '0);
        to_high_plus2();
        to_mid_high();
        chk(clk_out === '0, "R7 reset second phase", clk_out, '0);

        // Leave reset with everything off.
        @(negedge clk_sys);
        #3;
        en_all = 1'b0;
        rst = 1'b0;
        #40;

        // R3/R6: enable raised during a high phase.
        to_high_plus2();
        en_all = 1'b1;
        en_out = '1;
        to_mid_high();
        chk(clk_out === '0, "R3 mid-high enable ignored", clk_out, '0);
        @(negedge bpick);
        #3;
        chk(clk_out === '0, "R2 low after enabling edge", clk_out, '0);
        @(posedge bpick);
        #1;
        chk(clk_out === '1, "R6 first pulse starts at rising edge", clk_out, '1);
        #4;
        chk(clk_out === '1, "R6 first pulse mid", clk_out, '1);

        // R3/R5/R9: disable one lane during a high phase.
        to_high_plus2();
        en_out[2] = 1'b0;
        to_mid_high();
        chk(clk_out === '1, "R3 mid-high disable ignored", clk_out, '1);
        to_high_plus2();
        to_mid_high();
        chk(clk_out === 6'b111011, "R5 R9 lane 2 off others on", clk_out, 6'b111011);
        to_high_plus2();
        to_mid_high();
        chk(clk_out === 6'b111011, "R5 lane 2 stays off", clk_out, 6'b111011);

        // R4: common enable overrides individual enables.
        to_high_plus2();
        en_all = 1'b0;
        en_out = '1;
        to_high_plus2();
        to_mid_high();
        chk(clk_out === '0, "R4 common off", clk_out, '0);

        // R1: switch to the scan clock.
        @(negedge clk_sys);
        #3;
        switch_source(1'b1);
        en_all = 1'b1;
        en_out = 6'b010101;
        @(negedge bpick);
        #3;
        to_high_plus2();
        to_mid_high();
        chk(clk_out === 6'b010101, "R1 scan source", clk_out, 6'b010101);
        chk({N{clk_scan}} === 6'b111111, "R1 scan phase high", {N{clk_scan}}, '1);
        #30;
        chk(clk_out === '0, "R1 scan low phase", clk_out, '0);

        // Back to the system clock, then random traffic.
        @(negedge clk_sys);
        #3;
        switch_source(1'b0);
        en_all = 1'b1;

        for (int step = 0; step < 600; step++) begin
            int kind = $urandom_range(0, 99);
            if (kind < 3) begin
                switch_source(~sel_scan);
                en_all = 1'b1;
            end else if (kind < 6) begin
                rst = 1'b1;
                #70;
                to_mid_high_check_reset();
                rst = 1'b0;
            end else begin
                #(10 * $urandom_range(0, 3));
                if ($urandom_range(0, 1) == 1) begin
                    #4;
                    en_out = N'($urandom);
                    #6;
                end else begin
                    en_out = N'($urandom);
                end
                if ($urandom_range(0, 7) == 0) en_all = ~en_all;
                #10;
            end
        end
        #200;
        finish_run();
    end

    // Called with rst held for more than one selected period, at a time offset of 3 or 7 ns.
    task automatic to_mid_high_check_reset();
        @(posedge bpick);
        #(half_period(sel_scan) / 2);
        chk(clk_out === '0, "R7 reset in traffic", clk_out, '0);
        #(half_period(sel_scan) / 2 + 3);
    endtask
endmodule